// File: doc/BRIEF.md
# 4:2:2 Byte Stream Demultiplexer

This block receives a multiplexed YCbCr 4:2:2 video stream, one 8-bit byte per cycle of the double-rate pixel clock. It separates the stream into one luma sample per pixel and a co-sited Cb/Cr pair that covers two pixels. Horizontal sync arrives on its own active-low pin. Its falling edge sets the byte position counter back to zero, so a stream that loses alignment recovers at the next line.

Two static strap inputs tell the block which of the four orderings the source uses. One strap says whether a luma byte or a chroma byte comes first in each group of four bytes. The other says whether the first chroma byte of a group is Cb or Cr. Each group of four bytes becomes two pixels. When a group is complete, its two luma samples are clamped to the luma range and its chroma pair is clamped to the chroma range. The block then shows the pair with the first luma sample for one strobe and with the second luma sample for a second strobe. Any byte taken while sync is low is discarded, and so is every group that contains such a byte. In those cases the outputs show no valid pixels.

Top module: `yc422_demux`

## Requirements
- R1: While reset is high, and in the first cycle after it, pix_stb and valid are 0 and y_out, cb_out and cr_out are all zero.
- R2: Until the first hsync_n falling edge after reset, pix_stb and valid stay 0 whatever bytes arrive.
- R3: The byte sampled on the first clock edge at which hsync_n is low takes group position 0. Positions then advance by one per clock, modulo 4, both through the sync pulse and through the active line.
- R4: With luma_first=0 the positions 0..3 carry Y0, first chroma, Y1 and second chroma. With luma_first=1 they carry first chroma, Y0, second chroma and Y1.
- R5: With cr_first=0 the first chroma byte of a group is Cb and the second is Cr. With cr_first=1 the first is Cr and the second is Cb.
- R6: Suppose the position-3 byte is sampled with hsync_n high and all four bytes of its group were also sampled high. Then in the next cycle pix_stb=1, valid=1, y_out is Y0 of the group, and cb_out and cr_out hold the pair of the group.
- R7: Two cycles after the R6 strobe, pix_stb=1 again with y_out equal to Y1 and cb_out and cr_out unchanged. pix_stb is never high on two consecutive cycles. y_out, cb_out and cr_out change only in cycles where pix_stb is high.
- R8: Luma bytes are clamped to 16..235 (so 0 gives 16 and 255 gives 235).
- R9: Chroma bytes are clamped to 16..240 (so 0 gives 16, 255 gives 240 and 241 gives 240).
- R10: After any clock edge at which hsync_n is sampled low, valid=0 and pix_stb=0. A pending second pixel is dropped. A group that holds a byte sampled during sync is never emitted, but the outputs keep their last values.
- R11: Once valid rises, it stays 1 on the cycles between strobes for as long as hsync_n is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Double-rate pixel clock, one byte per cycle |
| rst | input | 1 | Synchronous active-high reset |
| hsync_n | input | 1 | Active-low horizontal sync |
| luma_first | input | 1 | Strap: 1 means chroma leads each group |
| cr_first | input | 1 | Strap: 1 means Cr is the first chroma byte |
| byte_in | input | 8 | Multiplexed sample byte |
| pix_stb | output | 1 | Pixel-rate strobe, one per pixel |
| valid | output | 1 | Outputs belong to an active line |
| y_out | output | 8 | Clamped luma of the strobed pixel |
| cb_out | output | 8 | Clamped Cb of the co-sited pair |
| cr_out | output | 8 | Clamped Cr of the co-sited pair |

## Verification
Two events can fall on the same clock edge: the second-pixel strobe of a group that has just been emitted, and the falling edge of sync that starts a new line. The bench provokes this by driving hsync_n low on exactly the byte at which the Y1 strobe is due. It then expects no strobe and valid low, while y_out and both chroma outputs keep the first pixel's values. The group that follows the sync pulse must still decode in the right order. A sync pulse whose length is not a multiple of four also leaves a partly covered group behind it, and the bench checks that this group is dropped.

// File: rtl/yc422_pkg.sv
package yc422_pkg;
    localparam int unsigned DW    = 8;
    localparam int unsigned SCALE = DW - 8;
    localparam int unsigned GROUP = 4;
    localparam int unsigned PW    = $clog2(GROUP);

    typedef logic [DW-1:0] samp_t;
    typedef logic [PW-1:0] pos_t;

    localparam samp_t LUMA_LO = samp_t'(16 << SCALE);
    localparam samp_t LUMA_HI = samp_t'(235 << SCALE);
    localparam samp_t CHR_LO  = samp_t'(16 << SCALE);
    localparam samp_t CHR_HI  = samp_t'(240 << SCALE);

    typedef enum logic [1:0] {ROLE_Y0, ROLE_Y1, ROLE_CB, ROLE_CR} role_e;

    typedef struct packed {
        samp_t y0;
        samp_t y1;
        samp_t cb;
        samp_t cr;
    } quad_t;

    function automatic samp_t clip(samp_t v, samp_t lo, samp_t hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    // bit 0 of the position tells luma from chroma, bit 1 tells first from second half
    function automatic role_e role_of(pos_t p, logic lf, logic cf);
        logic chroma;
        chroma = lf ? ~p[0] : p[0];
        if (chroma) return (cf ^ p[1]) ? ROLE_CR : ROLE_CB;
        return p[1] ? ROLE_Y1 : ROLE_Y0;
    endfunction
endpackage

// File: rtl/yc_phase_track.sv
module yc_phase_track
    import yc422_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hsync_n,
    output pos_t pos,
    output logic locked
);
    logic hs_q;
    pos_t cnt;
    logic fall;

    assign fall = hs_q & ~hsync_n;
    assign pos  = fall ? '0 : cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_q   <= 1'b1;
            cnt    <= '0;
            locked <= 1'b0;
        end else begin
            hs_q   <= hsync_n;
            cnt    <= pos_t'(pos + 1'b1);
            locked <= locked | fall;
        end
    end
endmodule

// File: rtl/yc_byte_sort.sv
module yc_byte_sort
    import yc422_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  samp_t byte_in,
    input  logic  hsync_n,
    input  pos_t  pos,
    input  logic  locked,
    input  logic  luma_first,
    input  logic  cr_first,
    output quad_t grp,
    output logic  done
);
    quad_t held;
    logic  ok_q;
    role_e role;

    assign role = role_of(pos, luma_first, cr_first);

    always_comb begin
        grp = held;
        case (role)
            ROLE_Y0: grp.y0 = clip(byte_in, LUMA_LO, LUMA_HI);
            ROLE_Y1: grp.y1 = clip(byte_in, LUMA_LO, LUMA_HI);
            ROLE_CB: grp.cb = clip(byte_in, CHR_LO, CHR_HI);
            ROLE_CR: grp.cr = clip(byte_in, CHR_LO, CHR_HI);
            default: grp = held;
        endcase
    end

    assign done = (pos == pos_t'(GROUP - 1)) & ok_q & hsync_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
            ok_q <= 1'b0;
        end else begin
            held <= grp;
            if (pos == '0) ok_q <= hsync_n & locked;
            else           ok_q <= ok_q & hsync_n;
        end
    end
endmodule

// File: rtl/yc_pixel_out.sv
module yc_pixel_out
    import yc422_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  hsync_n,
    input  logic  done,
    input  logic  second_slot,
    input  quad_t grp,
    output logic  pix_stb,
    output logic  valid,
    output samp_t y_out,
    output samp_t cb_out,
    output samp_t cr_out
);
    samp_t y1_q;
    logic  pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_stb <= 1'b0;
            valid   <= 1'b0;
            pend    <= 1'b0;
            y1_q    <= '0;
            y_out   <= '0;
            cb_out  <= '0;
            cr_out  <= '0;
        end else if (!hsync_n) begin
            pix_stb <= 1'b0;
            valid   <= 1'b0;
            pend    <= 1'b0;
        end else if (done) begin
            pix_stb <= 1'b1;
            valid   <= 1'b1;
            pend    <= 1'b1;
            y_out   <= grp.y0;
            y1_q    <= grp.y1;
            cb_out  <= grp.cb;
            cr_out  <= grp.cr;
        end else if (second_slot && pend) begin
            pix_stb <= 1'b1;
            pend    <= 1'b0;
            y_out   <= y1_q;
        end else begin
            pix_stb <= 1'b0;
        end
    end
endmodule

// File: rtl/yc422_demux.sv
module yc422_demux
    import yc422_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          hsync_n,
    input  logic          luma_first,
    input  logic          cr_first,
    input  logic [DW-1:0] byte_in,
    output logic          pix_stb,
    output logic          valid,
    output logic [DW-1:0] y_out,
    output logic [DW-1:0] cb_out,
    output logic [DW-1:0] cr_out
);
    pos_t  pos;
    logic  locked;
    quad_t grp;
    logic  done;

    yc_phase_track u_phase (
        .clk     (clk),
        .rst     (rst),
        .hsync_n (hsync_n),
        .pos     (pos),
        .locked  (locked)
    );

    yc_byte_sort u_sort (
        .clk        (clk),
        .rst        (rst),
        .byte_in    (byte_in),
        .hsync_n    (hsync_n),
        .pos        (pos),
        .locked     (locked),
        .luma_first (luma_first),
        .cr_first   (cr_first),
        .grp        (grp),
        .done       (done)
    );

    yc_pixel_out u_out (
        .clk         (clk),
        .rst         (rst),
        .hsync_n     (hsync_n),
        .done        (done),
        .second_slot (pos == pos_t'(1)),
        .grp         (grp),
        .pix_stb     (pix_stb),
        .valid       (valid),
        .y_out       (y_out),
        .cb_out      (cb_out),
        .cr_out      (cr_out)
    );
endmodule

// File: rtl/yc422_demux_chk.sv
module yc422_demux_chk
    import yc422_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          hsync_n,
    input logic          pix_stb,
    input logic          valid,
    input logic [DW-1:0] y_out,
    input logic [DW-1:0] cb_out,
    input logic [DW-1:0] cr_out
);
    logic hs_d, seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_d <= 1'b1;
            seen <= 1'b0;
        end else begin
            hs_d <= hsync_n;
            if (hs_d && !hsync_n) seen <= 1'b1;
        end
    end

    assert_no_stb_before_sync_R2: assert property (@(posedge clk) disable iff (rst)
        pix_stb |-> seen);
    assert_stb_implies_valid_R6: assert property (@(posedge clk) disable iff (rst)
        pix_stb |-> valid);
    assert_no_back_to_back_R7: assert property (@(posedge clk) disable iff (rst)
        pix_stb |=> !pix_stb);
    assert_hold_between_strobes_R7: assert property (@(posedge clk) disable iff (rst)
        !pix_stb |-> ($stable(y_out) && $stable(cb_out) && $stable(cr_out)));
    assert_luma_range_R8: assert property (@(posedge clk) disable iff (rst)
        valid |-> (y_out >= LUMA_LO && y_out <= LUMA_HI));
    assert_chroma_range_R9: assert property (@(posedge clk) disable iff (rst)
        valid |-> (cb_out >= CHR_LO && cb_out <= CHR_HI && cr_out >= CHR_LO && cr_out <= CHR_HI));
    assert_sync_blanks_R10: assert property (@(posedge clk) disable iff (rst)
        !hsync_n |=> (!valid && !pix_stb));
endmodule

bind yc422_demux yc422_demux_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .hsync_n (hsync_n),
    .pix_stb (pix_stb),
    .valid   (valid),
    .y_out   (y_out),
    .cb_out  (cb_out),
    .cr_out  (cr_out)
);

// File: tb/tb_yc422_demux.sv
module tb_yc422_demux;
    logic       clk = 1'b0;
    logic       rst;
    logic       hsync_n;
    logic       luma_first;
    logic       cr_first;
    logic [7:0] byte_in;
    logic       pix_stb, valid;
    logic [7:0] y_out, cb_out, cr_out;
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    yc422_demux dut (
        .clk(clk), .rst(rst), .hsync_n(hsync_n), .luma_first(luma_first),
        .cr_first(cr_first), .byte_in(byte_in), .pix_stb(pix_stb), .valid(valid),
        .y_out(y_out), .cb_out(cb_out), .cr_out(cr_out)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] lclip(logic [7:0] v);
        return (v < 16) ? 8'd16 : (v > 235) ? 8'd235 : v;
    endfunction
    function automatic logic [7:0] cclip(logic [7:0] v);
        return (v < 16) ? 8'd16 : (v > 240) ? 8'd240 : v;
    endfunction

    // expected split of one four-byte group from the ordering rules
    task automatic decode(input bit l, input bit c, input logic [7:0] b0, b1, b2, b3,
                          output logic [7:0] y0, y1, cb, cr);
        logic [7:0] ca, cz;
        if (!l) begin y0 = b0; ca = b1; y1 = b2; cz = b3; end
        else    begin ca = b0; y0 = b1; cz = b2; y1 = b3; end
        cb = c ? cz : ca;
        cr = c ? ca : cz;
        y0 = lclip(y0); y1 = lclip(y1); cb = cclip(cb); cr = cclip(cr);
    endtask

    task automatic feed(input logic [7:0] b, input logic hs);
        @(negedge clk);
        byte_in = b;
        hsync_n = hs;
        @(posedge clk);
        #1;
    endtask

    task automatic sync(input int n);
        for (int k = 0; k < n; k++) begin
            feed(8'h10, 1'b0);
            chk("R10", "stb in sync", int'(pix_stb), 0);
            chk("R10", "valid in sync", int'(valid), 0);
        end
    endtask

    task automatic run_line(input bit l, input bit c, input logic [7:0] d [12], input string req);
        logic [7:0] y0, y1, cb, cr;
        luma_first = l;
        cr_first = c;
        sync(8);
        for (int i = 0; i < 12; i++) begin
            feed(d[i], 1'b1);
            if (i % 4 == 3) begin
                decode(l, c, d[i-3], d[i-2], d[i-1], d[i], y0, y1, cb, cr);
                chk("R6", "first stb", int'(pix_stb), 1);
                chk("R6", "valid", int'(valid), 1);
                chk(req, "y0", int'(y_out), int'(y0));
                chk(req, "cb", int'(cb_out), int'(cb));
                chk(req, "cr", int'(cr_out), int'(cr));
            end else if (i % 4 == 1 && i >= 4) begin
                decode(l, c, d[i-5], d[i-4], d[i-3], d[i-2], y0, y1, cb, cr);
                chk("R7", "second stb", int'(pix_stb), 1);
                chk(req, "y1", int'(y_out), int'(y1));
                chk("R7", "cb held", int'(cb_out), int'(cb));
                chk("R7", "cr held", int'(cr_out), int'(cr));
            end else begin
                chk("R7", "idle stb", int'(pix_stb), 0);
                chk("R11", "valid between", int'(valid), (i >= 3) ? 1 : 0);
            end
        end
    endtask

    task automatic t_reset;
        rst = 1'b1; hsync_n = 1'b1; luma_first = 1'b0; cr_first = 1'b0; byte_in = 8'h55;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "stb in reset", int'(pix_stb), 0);
        chk("R1", "valid in reset", int'(valid), 0);
        chk("R1", "y in reset", int'(y_out), 0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        chk("R1", "stb after reset", int'(pix_stb), 0);
        chk("R1", "cb after reset", int'(cb_out), 0);
        chk("R1", "cr after reset", int'(cr_out), 0);
    endtask

    task automatic t_prelock;
        for (int k = 0; k < 10; k++) begin
            feed(8'(8'h40 + k), 1'b1);
            chk("R2", "stb before sync", int'(pix_stb), 0);
            chk("R2", "valid before sync", int'(valid), 0);
        end
    endtask

    task automatic t_orders;
        logic [7:0] d [12];
        d = '{8'h20, 8'h80, 8'h30, 8'h90, 8'h40, 8'h70, 8'h50, 8'hA0, 8'h60, 8'h68, 8'h64, 8'h78};
        run_line(1'b0, 1'b0, d, "R4");
        run_line(1'b0, 1'b1, d, "R5");
        run_line(1'b1, 1'b0, d, "R4");
        run_line(1'b1, 1'b1, d, "R5");
    endtask

    task automatic t_clamp;
        logic [7:0] d [12];
        d = '{8'h00, 8'h00, 8'hFF, 8'hFF, 8'hEB, 8'hF0, 8'hEC, 8'hF1, 8'h0F, 8'h0F, 8'h10, 8'h10};
        run_line(1'b0, 1'b0, d, "R8 R9");
        run_line(1'b1, 1'b0, d, "R8 R9");
    endtask

    task automatic t_odd_sync;
        logic [7:0] y0, y1, cb, cr;
        luma_first = 1'b0; cr_first = 1'b0;
        sync(6);
        feed(8'h33, 1'b1);
        chk("R3", "stb pos2", int'(pix_stb), 0);
        feed(8'h44, 1'b1);
        chk("R10", "partial group dropped", int'(pix_stb), 0);
        chk("R10", "partial group valid", int'(valid), 0);
        feed(8'h21, 1'b1); feed(8'h81, 1'b1); feed(8'h31, 1'b1); feed(8'h91, 1'b1);
        decode(1'b0, 1'b0, 8'h21, 8'h81, 8'h31, 8'h91, y0, y1, cb, cr);
        chk("R3", "stb after odd sync", int'(pix_stb), 1);
        chk("R3", "y0 after odd sync", int'(y_out), int'(y0));
        chk("R3", "cb after odd sync", int'(cb_out), int'(cb));
    endtask

    task automatic t_collide;
        logic [7:0] y0, y1, cb, cr;
        luma_first = 1'b0; cr_first = 1'b1;
        sync(8);
        feed(8'h22, 1'b1); feed(8'h82, 1'b1); feed(8'h32, 1'b1); feed(8'h92, 1'b1);
        decode(1'b0, 1'b1, 8'h22, 8'h82, 8'h32, 8'h92, y0, y1, cb, cr);
        chk("R6", "stb before collide", int'(pix_stb), 1);
        feed(8'h23, 1'b1);
        feed(8'h83, 1'b0);
        chk("R10", "stb at sync collide", int'(pix_stb), 0);
        chk("R10", "valid at sync collide", int'(valid), 0);
        chk("R10", "y held at collide", int'(y_out), int'(y0));
        chk("R10", "cr held at collide", int'(cr_out), int'(cr));
        sync(7);
        feed(8'h24, 1'b1); feed(8'h84, 1'b1); feed(8'h34, 1'b1); feed(8'h94, 1'b1);
        decode(1'b0, 1'b1, 8'h24, 8'h84, 8'h34, 8'h94, y0, y1, cb, cr);
        chk("R3", "realigned stb", int'(pix_stb), 1);
        chk("R3", "realigned y0", int'(y_out), int'(y0));
        chk("R5", "realigned cr", int'(cr_out), int'(cr));
        feed(8'h25, 1'b1); feed(8'h85, 1'b0);
        chk("R10", "late group dropped", int'(pix_stb), 0);
    endtask

    initial begin
        t_reset;
        t_prelock;
        t_orders;
        t_clamp;
        t_odd_sync;
        t_collide;
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule